// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits behind a two-wire serial memory protocol engine. It gathers the data bytes of one write transaction into a page buffer. When the transaction ends, it writes them into the memory array together in one programming pass. The protocol engine supplies three things: a begin event carrying the starting word address, one strobe per received data byte, and a commit event raised on the bus stop condition. The block drives a write port toward the array: enable, address and data. It also drives a busy flag that the protocol engine uses to withhold acknowledges while the self-timed programming interval runs. A cycle counter models that interval.

Only the low offset bits of the address pointer advance, so a page wraps onto itself. If a transaction sends more bytes than a page holds, the later bytes replace the earlier ones. A per-offset loaded mask makes the commit write only the offsets that were actually received. A write-protect input is sampled when the commit event arrives. Depending on a variant parameter, a high level guards either the whole array or only its upper quarter. A commit with nothing writable starts no programming and never raises busy. After a commit, the shared address pointer is left one past the last loaded byte, within the same page, for a following current-address read.

Top module: `page_write_commit`

## Requirements
- R1: After reset, busy and arr_we are 0 and ptr_addr is 0.
- R2: A begin event loads ptr_addr with wr_addr. Each accepted byte strobe increments only the low five bits of ptr_addr and keeps the upper bits fixed. After commit, ptr_addr is therefore one past the last loaded offset, inside the same page.
- R3: Incrementing from offset 31 goes to offset 0 of the same page. A byte sent to an offset that is already loaded replaces the earlier byte, so only the last value per offset is committed.
- R4: arr_we stays 0 until a commit event. During a commit, each loaded offset is written exactly once, in ascending offset order, at address {page, offset}. Offsets that were not loaded are not written.
- R5: An accepted commit raises busy on the next cycle. busy then stays high for exactly PAGE_BYTES + PROG_CYCLES cycles.
- R6: While busy is high, begin, byte and commit inputs have no effect: ptr_addr and the write port are unchanged, and no second commit follows.
- R7: A commit event with no loaded byte writes nothing and leaves busy low.
- R8: With wp_in low at the commit event, no address is protected.
- R9: With PROT_QUARTER = 0 and wp_in high at the commit event, nothing is written and busy stays low.
- R10: With PROT_QUARTER = 1 and wp_in high at the commit event, pages whose two top address bits are 11 are not written and busy stays low. Pages elsewhere commit normally.
- R11: Only the level of wp_in in the commit cycle matters. Its level during byte loading has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_begin | input | 1 | Start of a write transaction; loads the pointer and clears the loaded mask |
| wr_addr | input | ADDR_W | Starting word address for wr_begin |
| byte_stb | input | 1 | One received data byte |
| byte_data | input | DATA_W | Data for byte_stb |
| stop_commit | input | 1 | Stop condition: commit the buffered page |
| wp_in | input | 1 | Write-protect level |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| busy | output | 1 | Commit or programming in progress |
| ptr_addr | output | ADDR_W | Shared address pointer |

## Verification
The bench builds two instances and drives both with the same stimulus. The first has a 13-bit address, upper-quarter protection and a 40-cycle programming interval. The second has a 12-bit address, whole-array protection and a 25-cycle interval. Short intervals make the exact busy width countable, and inputs sent while busy can be shown to be ignored within a few hundred cycles. Because the two variants share stimulus, one transaction under wp_in high shows the same page blocked by one variant and written by the other, and the upper-quarter boundary at 0x1800 becomes reachable.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_PROG = 2'd2
  } pwb_state_t;
endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              any_vld
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  // plain dual-port storage, no reset, registered read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= vld_q[rd_idx];
      if (clr)        vld_q <= '0;
      else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end
  end

  assign any_vld = |vld_q;

  // R3: a loaded offset stays loaded until an explicit clear
  a_r3_mask_sticky: assert property (@(posedge clk) disable iff (rst)
    (!clr && !wr_en) |=> $stable(vld_q));
endmodule

// File: rtl/pwb_protect.sv
module pwb_protect #(
  parameter int PG_W         = 7,
  parameter bit PROT_QUARTER = 1'b0
) (
  input  logic            wp,
  input  logic [PG_W-1:0] page,
  output logic            blocked
);
  generate
    if (PROT_QUARTER) begin : g_quarter
      assign blocked = wp && (page[PG_W-1:PG_W-2] == 2'b11);
    end else begin : g_whole
      assign blocked = wp;
    end
  endgenerate
endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
  parameter int CYCLES = 500000,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= CNT_W'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CNT_W'(1));

  // R5: once running, the count only moves down by one per cycle
  a_r5_timer_steps: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int PROG_CYCLES  = 500000,
  parameter bit PROT_QUARTER = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_commit,
  input  logic              wp_in,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr_addr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  pwb_state_t state;
  logic [PG_W-1:0]   page_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  scan_idx;
  logic [OFF_W-1:0]  scan_idx_d;
  logic              scan_go_d;
  logic              wp_smp;

  logic              idle;
  logic              take_begin, take_byte, take_stop;
  logic              blocked, go_commit, scan_last;
  logic              st_clr;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld, any_vld;
  logic              prog_load, prog_done;

  assign idle       = (state == ST_IDLE);
  assign take_begin = idle && wr_begin;
  assign take_byte  = idle && !wr_begin && byte_stb;
  assign take_stop  = idle && !wr_begin && !byte_stb && stop_commit;
  assign go_commit  = take_stop && any_vld && !blocked;
  assign scan_last  = (state == ST_SCAN) && (scan_idx == OFF_W'(PAGE_BYTES - 1));
  assign st_clr     = take_begin || (take_stop && !go_commit) || scan_last;
  assign prog_load  = scan_last;

  pwb_page_store #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (take_byte),
    .wr_idx  (off_q),
    .wr_data (byte_data),
    .clr     (st_clr),
    .rd_idx  (scan_idx),
    .rd_data (rd_data),
    .rd_vld  (rd_vld),
    .any_vld (any_vld)
  );

  pwb_protect #(.PG_W(PG_W), .PROT_QUARTER(PROT_QUARTER)) u_prot (
    .wp      (wp_in),
    .page    (page_q),
    .blocked (blocked)
  );

  pwb_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (prog_load),
    .done (prog_done)
  );

  // control and address pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      page_q   <= '0;
      off_q    <= '0;
      scan_idx <= '0;
      wp_smp   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_begin) begin
            page_q <= wr_addr[ADDR_W-1:OFF_W];
            off_q  <= wr_addr[OFF_W-1:0];
          end else if (take_byte) begin
            off_q  <= off_q + 1'b1;
          end else if (take_stop) begin
            wp_smp <= wp_in;
            if (go_commit) begin
              state    <= ST_SCAN;
              scan_idx <= '0;
            end
          end
        end
        ST_SCAN: begin
          scan_idx <= scan_idx + 1'b1;
          if (scan_last) state <= ST_PROG;
        end
        ST_PROG: begin
          if (prog_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // commit pipeline toward the array
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_go_d  <= 1'b0;
      scan_idx_d <= '0;
      arr_we     <= 1'b0;
      arr_addr   <= '0;
      arr_data   <= '0;
    end else begin
      scan_go_d  <= (state == ST_SCAN);
      scan_idx_d <= scan_idx;
      arr_we     <= scan_go_d && rd_vld;
      arr_addr   <= {page_q, scan_idx_d};
      arr_data   <= rd_data;
    end
  end

  assign busy     = !idle;
  assign ptr_addr = {page_q, off_q};

  // R1: quiet after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!arr_we && !busy && ptr_addr == '0));

  // R2: a byte moves only the low offset bits, by one
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (idle && !wr_begin && byte_stb) |=>
      (ptr_addr[ADDR_W-1:OFF_W] == $past(ptr_addr[ADDR_W-1:OFF_W])) &&
      (ptr_addr[OFF_W-1:0] == $past(ptr_addr[OFF_W-1:0]) + 1'b1));

  // R4: the array sees writes only inside a commit
  a_r4_write_in_commit: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R4: commit writes stay inside the buffered page
  a_r4_write_page: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_addr[ADDR_W-1:OFF_W] == page_q));

  // R6: pointer frozen while busy
  a_r6_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr_addr));

  // R7: empty commit never raises busy
  a_r7_empty_stop: assert property (@(posedge clk) disable iff (rst)
    (!busy && stop_commit && !any_vld) |=> !busy);

  generate
    if (PROT_QUARTER) begin : g_chk_quarter
      // R10: no write lands in the upper quarter under a sampled protect
      a_r10_quarter_guard: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> !(wp_smp && arr_addr[ADDR_W-1:ADDR_W-2] == 2'b11));
    end else begin : g_chk_whole
      // R9: no write at all under a sampled protect
      a_r9_whole_guard: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> !wp_smp);
    end
  endgenerate
endmodule

// File: tb/sim_page_write_commit.sv
module sim_page_write_commit;
  localparam int CLK_PERIOD = 10;
  localparam int P0 = 40;
  localparam int P1 = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_begin = 1'b0;
  logic [12:0] addr_in = '0;
  logic        byte_stb = 1'b0;
  logic [7:0]  data_in = '0;
  logic        stop_commit = 1'b0;
  logic        wp = 1'b0;

  logic        we0, we1, busy0, busy1;
  logic [12:0] aa0, ptr0;
  logic [11:0] aa1, ptr1;
  logic [7:0]  ad0, ad1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_commit #(.ADDR_W(13), .PROG_CYCLES(P0), .PROT_QUARTER(1'b1)) u0 (
    .clk(clk), .rst(rst), .wr_begin(wr_begin), .wr_addr(addr_in),
    .byte_stb(byte_stb), .byte_data(data_in), .stop_commit(stop_commit),
    .wp_in(wp), .arr_we(we0), .arr_addr(aa0), .arr_data(ad0),
    .busy(busy0), .ptr_addr(ptr0));

  page_write_commit #(.ADDR_W(12), .PROG_CYCLES(P1), .PROT_QUARTER(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_begin(wr_begin), .wr_addr(addr_in[11:0]),
    .byte_stb(byte_stb), .byte_data(data_in), .stop_commit(stop_commit),
    .wp_in(wp), .arr_we(we1), .arr_addr(aa1), .arr_data(ad1),
    .busy(busy1), .ptr_addr(ptr1));

  // write logs and busy-width counters
  logic [12:0] la0 [64];
  logic [7:0]  ld0 [64];
  logic [11:0] la1 [64];
  logic [7:0]  ld1 [64];
  int n0 = 0, n1 = 0, bc0 = 0, bc1 = 0;

  always @(negedge clk) begin
    if (we0) begin
      if (n0 < 64) begin la0[n0] = aa0; ld0[n0] = ad0; end
      n0++;
    end
    if (we1) begin
      if (n1 < 64) begin la1[n1] = aa1; ld1[n1] = ad1; end
      n1++;
    end
    if (busy0) bc0++;
    if (busy1) bc1++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    n0 = 0; n1 = 0; bc0 = 0; bc1 = 0;
  endtask

  task automatic do_begin(input logic [12:0] a);
    @(negedge clk); wr_begin = 1'b1; addr_in = a;
    @(negedge clk); wr_begin = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); byte_stb = 1'b1; data_in = d;
    @(negedge clk); byte_stb = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_commit = 1'b1;
    @(negedge clk); stop_commit = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy0 && !busy1) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 busy0", busy0, 0);
    check("R1 we0", we0, 0);
    check("R1 ptr0", ptr0, 0);
    check("R1 ptr1", ptr1, 0);
  endtask

  task automatic t_byte_write();
    clear_logs(); wp = 1'b0;
    do_begin(13'h0123); do_byte(8'hA5);
    repeat (3) @(negedge clk);
    check("R4 no write before stop", n0, 0);
    check("R2 ptr after byte", ptr0, 13'h0124);
    do_stop();
    // R6: junk while busy
    repeat (4) @(negedge clk);
    do_begin(13'h0700); do_byte(8'h11); do_stop();
    wait_idle();
    check("R4 one write u0", n0, 1);
    check("R4 addr u0", la0[0], 13'h0123);
    check("R4 data u0", ld0[0], 8'hA5);
    check("R8 write u1", n1, 1);
    check("R5 busy width u0", bc0, 32 + P0);
    check("R5 busy width u1", bc1, 32 + P1);
    check("R6 ptr unchanged", ptr0, 13'h0124);
    clear_logs();
    repeat (10) @(negedge clk);
    check("R6 no second commit", bc0 + n0, 0);
  endtask

  task automatic t_wrap();
    clear_logs(); wp = 1'b0;
    do_begin(13'h045E);
    do_byte(8'h30); do_byte(8'h31); do_byte(8'h40);
    check("R3 ptr wraps", ptr0, 13'h0441);
    do_stop(); wait_idle();
    check("R4 three writes", n0, 3);
    check("R3 first in order", la0[0], 13'h0440);
    check("R3 wrapped data", ld0[0], 8'h40);
    check("R4 second", la0[1], 13'h045E);
    check("R4 third", la0[2], 13'h045F);
    check("R2 ptr after commit", ptr0, 13'h0441);
  endtask

  task automatic t_overflow();
    clear_logs(); wp = 1'b0;
    do_begin(13'h0200);
    for (int i = 0; i < 34; i++) do_byte(8'(i));
    do_stop(); wait_idle();
    check("R3 full page", n0, 32);
    check("R3 overwrite 0", ld0[0], 32);
    check("R3 overwrite 1", ld0[1], 33);
    check("R3 kept 5", ld0[5], 5);
    check("R3 addr 31", la0[31], 13'h021F);
    check("R2 ptr", ptr0, 13'h0202);
  endtask

  task automatic t_empty_stop();
    clear_logs(); wp = 1'b0;
    do_begin(13'h0300); do_stop();
    repeat (10) @(negedge clk);
    check("R7 no busy", bc0 + bc1, 0);
    check("R7 no write", n0 + n1, 0);
  endtask

  task automatic t_protect();
    clear_logs(); wp = 1'b1;
    do_begin(13'h1820); do_byte(8'h77); do_stop(); wait_idle();
    check("R10 top quarter blocked", n0, 0);
    check("R10 no busy", bc0, 0);
    check("R9 whole blocked", n1, 0);
    check("R9 no busy", bc1, 0);
    clear_logs();
    do_begin(13'h0100); do_byte(8'h5C); do_stop(); wait_idle();
    check("R10 lower written", n0, 1);
    check("R10 lower data", ld0[0], 8'h5C);
    check("R9 whole still blocked", n1, 0);
    clear_logs(); wp = 1'b0;
    do_begin(13'h1820); do_byte(8'h66); do_stop(); wait_idle();
    check("R8 top written", n0, 1);
    check("R8 top addr", la0[0], 13'h1820);
    check("R8 u1 written", n1, 1);
  endtask

  task automatic t_wp_sample();
    clear_logs(); wp = 1'b1;
    do_begin(13'h1900); do_byte(8'h9A);
    wp = 1'b0; do_stop(); wp = 1'b0; wait_idle();
    check("R11 high while loading ignored", n0, 1);
    check("R11 u1 also", n1, 1);
    clear_logs();
    do_begin(13'h1904); do_byte(8'h9B);
    @(negedge clk); wp = 1'b1; stop_commit = 1'b1;
    @(negedge clk); stop_commit = 1'b0; wp = 1'b0;
    wait_idle();
    check("R11 high at commit blocks u0", n0, 0);
    check("R11 high at commit blocks u1", n1, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_wrap();
    t_overflow();
    t_empty_stop();
    t_protect();
    t_wp_sample();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule